// File: doc/BRIEF.md
# System Configuration Register Bank

This block holds a set of 32-bit system configuration registers behind a simple word-addressed bus. A request strobe, a write enable, a byte address, write data, read data and a ready signal carry every access. The bank only keeps register state. Memory remapping, SRAM erase and SRAM write protection are not carried out here; other logic reads the stored bits and acts on them.

Each register follows its own write rule. Some fields are plain masked stores. One bit can only be cleared by software. The lock bits can only be set by software. One status flag is cleared by writing a one to it. The protection registers collect every bit ever written to them. A hardware pulse input sets the parity-error flag. The four interrupt source-selection registers are also sent out as one flat bus to the external line selector.

A request takes one cycle. Ready, read data and an error pulse appear in the cycle after the strobe is sampled. An access to an unmapped or misaligned address reads zero, changes nothing, and raises the error pulse.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset, the register at offset 0x04 reads 0x7C000001. Every other mapped offset reads 0x00000000, and `src_sel` is all zero.
- R2: A write to offset 0x00 stores the written value ANDed with 0x00000107.
- R3: At offset 0x04, bit 0 takes (old AND written value), so software can clear it but never set it. Bits in mask 0xFCFF0100 take the written value. All other bits read zero.
- R4: Offsets 0x08, 0x0C, 0x10 and 0x14 are selection registers 0 to 3. Each stores the low 16 bits of the written value and reads them back. Register k drives `src_sel[16k+15:16k]`.
- R5: At offset 0x1C, bits [3:0] are lock bits. A written 1 sets a bit, a written 0 has no effect, and only reset clears them. The other bits of this register, except bit 8, read zero.
- R6: Offset 0x1C bit 8 is a status flag. Writing 1 to it clears it, and writing 0 leaves it unchanged. A one-cycle pulse on `parity_err_in` sets it. If the pulse and a clearing write fall in the same cycle, the flag ends up set.
- R7: Offsets 0x20 and 0x28 OR the written value into their contents. Only reset clears their bits.
- R8: Offset 0x24 stores only the low 8 bits of the written value.
- R9: Offset 0x18 always reads zero, and writes to it have no effect.
- R10: An access to a byte address that is not a multiple of 4, or whose word index is above 10, reads zero and changes no register. It also raises `bus_err` for one cycle, together with `bus_ready`.
- R11: A request sampled at a clock edge gives `bus_ready` high for exactly the next cycle, with the read data valid in that cycle. Without a request, `bus_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (10) | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completed |
| bus_err | output | 1 | Unmapped or misaligned access |
| parity_err_in | input | 1 | Pulse that sets the parity-error flag |
| src_sel | output | 64 | Four 16-bit source-selection fields, register 0 in the low bits |

## Verification
The hardest situation to reach is the parity pulse landing in the same cycle as a write that clears the flag. Either order on separate cycles would hide a priority error. The bench drives the pulse from the same task call that issues the clearing write, so both are sampled at one edge, and then reads the flag back. The clear-only bit at 0x04 is also hard to check once it has been cleared. A walking-ones sweep first writes a pattern with only bit 0 set to prove the bit survives, then keeps writing patterns with bit 0 set to prove it never comes back. A second reset then shows that the sticky lock and protection bits return to zero.

// File: rtl/cfg_regs_pkg.sv
package cfg_regs_pkg;

    localparam int NUM_SEL   = 4;
    localparam int SEL_W     = 16;
    localparam int REG_COUNT = 11;

    typedef enum logic [3:0] {
        RG_REMAP  = 4'd0,
        RG_CFG1   = 4'd1,
        RG_SEL0   = 4'd2,
        RG_SEL1   = 4'd3,
        RG_SEL2   = 4'd4,
        RG_SEL3   = 4'd5,
        RG_SRAMCS = 4'd6,
        RG_CFG2   = 4'd7,
        RG_WP1    = 4'd8,
        RG_KEY    = 4'd9,
        RG_WP2    = 4'd10,
        RG_NONE   = 4'd15
    } reg_id_e;

    localparam logic [31:0] REMAP_MASK     = 32'h0000_0107;
    localparam logic [31:0] CFG1_MASK      = 32'hFCFF_0100;
    localparam logic [31:0] CFG1_CLR_ONLY  = 32'h0000_0001;
    localparam logic [31:0] CFG1_RESET     = 32'h7C00_0001;
    localparam logic [31:0] CFG2_LOCKS     = 32'h0000_000F;
    localparam logic [31:0] CFG2_PAR_FLAG  = 32'h0000_0100;
    localparam logic [31:0] KEY_MASK       = 32'h0000_00FF;

    typedef struct packed {
        logic [31:0]                      remap;
        logic [31:0]                      cfg1;
        logic [NUM_SEL-1:0][SEL_W-1:0]    sel;
        logic [31:0]                      cfg2;
        logic [31:0]                      wp1;
        logic [31:0]                      key;
        logic [31:0]                      wp2;
    } bank_t;

    typedef struct packed {
        logic        ready;
        logic        err;
        logic [31:0] rdata;
    } resp_t;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_regs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           id
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;

    always_comb begin
        widx = addr[ADDR_W-1:2];
        id   = RG_NONE;
        if (addr[1:0] == 2'b00 && widx < IDX_W'(REG_COUNT)) begin
            id = reg_id_e'(widx[3:0]);
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_regs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  reg_id_e                  id,
    input  logic [31:0]              wdata,
    input  logic                     parity_set,
    output logic [31:0]              rd_val,
    output logic [NUM_SEL*SEL_W-1:0] sel_flat
);
    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (id)
                RG_REMAP: bank_d.remap = wdata & REMAP_MASK;
                RG_CFG1:  bank_d.cfg1  = (bank_q.cfg1 & wdata & CFG1_CLR_ONLY)
                                       | (wdata & CFG1_MASK);
                RG_CFG2:  bank_d.cfg2  = (bank_q.cfg2 | (wdata & CFG2_LOCKS))
                                       & ~(wdata & CFG2_PAR_FLAG);
                RG_WP1:   bank_d.wp1   = bank_q.wp1 | wdata;
                RG_KEY:   bank_d.key   = wdata & KEY_MASK;
                RG_WP2:   bank_d.wp2   = bank_q.wp2 | wdata;
                default:  ;
            endcase
            for (int k = 0; k < NUM_SEL; k++) begin
                if (int'(id) == int'(RG_SEL0) + k) begin
                    bank_d.sel[k] = wdata[SEL_W-1:0];
                end
            end
        end
        if (parity_set) begin
            bank_d.cfg2 = bank_d.cfg2 | CFG2_PAR_FLAG;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q      <= '0;
            bank_q.cfg1 <= CFG1_RESET;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rd_val = '0;
        case (id)
            RG_REMAP: rd_val = bank_q.remap;
            RG_CFG1:  rd_val = bank_q.cfg1;
            RG_CFG2:  rd_val = bank_q.cfg2;
            RG_WP1:   rd_val = bank_q.wp1;
            RG_KEY:   rd_val = bank_q.key;
            RG_WP2:   rd_val = bank_q.wp2;
            default:  rd_val = '0;
        endcase
        for (int k = 0; k < NUM_SEL; k++) begin
            if (int'(id) == int'(RG_SEL0) + k) begin
                rd_val = {{(32-SEL_W){1'b0}}, bank_q.sel[k]};
            end
        end
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel_out
        assign sel_flat[g*SEL_W +: SEL_W] = bank_q.sel[g];
    end

    // R3
    clr_only_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_q.cfg1[0] |=> !bank_q.cfg1[0]);

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(bank_q.cfg2[3:0]) & ~bank_q.cfg2[3:0]) == 4'b0));

    // R7
    prot_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(bank_q.wp1) & ~bank_q.wp1) | ($past(bank_q.wp2) & ~bank_q.wp2)) == 32'b0));

    // R6
    parity_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parity_set |=> bank_q.cfg2[8]);
endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
    import cfg_regs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              bus_err,
    input  logic              parity_err_in,
    output logic [63:0]       src_sel
);
    localparam int SEL_BUS_W = NUM_SEL * SEL_W;

    reg_id_e               id;
    logic [31:0]           rd_val;
    logic                  wr_en;
    logic [SEL_BUS_W-1:0]  sel_flat;
    resp_t                 resp_d, resp_q;

    cfg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .id   (id)
    );

    assign wr_en = bus_req && bus_we && (id != RG_NONE);

    cfg_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .id         (id),
        .wdata      (bus_wdata),
        .parity_set (parity_err_in),
        .rd_val     (rd_val),
        .sel_flat   (sel_flat)
    );

    always_comb begin
        resp_d.ready = bus_req;
        resp_d.err   = bus_req && (id == RG_NONE);
        resp_d.rdata = (bus_req && !bus_we) ? rd_val : 32'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign bus_ready = resp_q.ready;
    assign bus_err   = resp_q.err;
    assign bus_rdata = resp_q.rdata;
    assign src_sel   = 64'(sel_flat);

    // R11
    ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ready);

    // R11
    no_spurious_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> $past(bus_req));

    // R10
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_ready && bus_rdata == 32'b0));
endmodule

// File: tb/sys_cfg_regs_test.sv
`timescale 1ns/1ps
module sys_cfg_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        bus_err;
    logic        parity_err_in = 1'b0;
    logic [63:0] src_sel;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [0:10];

    always #2.5 clk = ~clk;

    sys_cfg_regs #(.ADDR_W(10)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err),
        .parity_err_in(parity_err_in), .src_sel(src_sel)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int idx);
        case (idx)
            0: return "R2";
            1: return "R3";
            2, 3, 4, 5: return "R4";
            6: return "R9";
            7: return "R5";
            8, 10: return "R7";
            9: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic bit mapped(input logic [9:0] a);
        return (a[1:0] == 2'b00) && (a[9:2] <= 8'd10);
    endfunction

    function automatic logic [63:0] sel_model();
        return {m[5][15:0], m[4][15:0], m[3][15:0], m[2][15:0]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i <= 10; i++) m[i] = 32'h0;
        m[1] = 32'h7C00_0001;
    endtask

    task automatic model_write(input int idx, input logic [31:0] d);
        case (idx)
            0: m[0] = d & 32'h0000_0107;
            1: m[1] = (m[1] & d & 32'h1) | (d & 32'hFCFF_0100);
            2, 3, 4, 5: m[idx] = d & 32'h0000_FFFF;
            7: m[7] = (m[7] | (d & 32'hF)) & ~(d & 32'h100);
            8, 10: m[idx] = m[idx] | d;
            9: m[9] = d & 32'hFF;
            default: ;
        endcase
    endtask

    // one access: drive at a falling edge, sample at the next falling edge
    task automatic access(input bit we, input logic [9:0] a, input logic [31:0] d,
                          input bit par, input string tag);
        logic [31:0] exp_rd;
        bit ok;
        ok = mapped(a);
        exp_rd = (!we && ok) ? m[a[9:2]] : 32'h0;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; parity_err_in = par;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; parity_err_in = 1'b0;
        if (we && ok) model_write(int'(a[9:2]), d);
        if (par) m[7] = m[7] | 32'h100;
        chk({tag, " ready (R11)"}, 64'(bus_ready), 64'd1);
        chk({tag, " err (R10)"}, 64'(bus_err), ok ? 64'd0 : 64'd1);
        if (!we) chk({tag, " rdata"}, 64'(bus_rdata), 64'(exp_rd));
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i <= 10; i++) access(1'b0, 10'(i * 4), 32'h0, 1'b0, tag);
        chk({tag, " src_sel (R4)"}, src_sel, sel_model());
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        chk("R1 src_sel after reset", src_sel, 64'h0);
        check_all("R1");

        // sweep every mapped offset with walking ones and fixed patterns
        for (int r = 0; r <= 10; r++) begin
            for (int i = 0; i < 38; i++) begin
                logic [31:0] p;
                case (i)
                    32: p = 32'hFFFF_FFFF;
                    33: p = 32'h0000_0000;
                    34: p = 32'hA5A5_A5A5;
                    35: p = 32'h5A5A_5A5A;
                    36: p = 32'h0000_0100;
                    37: p = 32'h1234_5678;
                    default: p = 32'h1 << i;
                endcase
                access(1'b1, 10'(r * 4), p, 1'b0, tag_of(r));
                access(1'b0, 10'(r * 4), 32'h0, 1'b0, tag_of(r));
                chk({tag_of(r), " src_sel (R4)"}, src_sel, sel_model());
            end
        end

        // parity flag: pulse sets, W1C clears, write 0 keeps, collision sets
        access(1'b0, 10'h24, 32'h0, 1'b1, "R6 pulse");
        access(1'b0, 10'h1C, 32'h0, 1'b0, "R6 set by pulse");
        chk("R6 flag set", 64'(m[7][8]), 64'd1);
        access(1'b1, 10'h1C, 32'h0, 1'b0, "R6 write0");
        access(1'b0, 10'h1C, 32'h0, 1'b0, "R6 kept after write0");
        access(1'b1, 10'h1C, 32'h100, 1'b0, "R6 w1c");
        access(1'b0, 10'h1C, 32'h0, 1'b0, "R6 cleared");
        access(1'b1, 10'h1C, 32'h100, 1'b1, "R6 collision");
        access(1'b0, 10'h1C, 32'h0, 1'b0, "R6 set wins");

        // unmapped and misaligned accesses
        for (int u = 0; u < 6; u++) begin
            logic [9:0] ua;
            case (u)
                0: ua = 10'h02C;
                1: ua = 10'h030;
                2: ua = 10'h3FC;
                3: ua = 10'h005;
                4: ua = 10'h00E;
                default: ua = 10'h023;
            endcase
            access(1'b0, ua, 32'h0, 1'b0, "R10 read");
            access(1'b1, ua, 32'hFFFF_FFFF, 1'b0, "R10 write");
        end
        check_all("R10 no side effect");

        // ready drops when idle
        @(negedge clk);
        chk("R11 idle ready", 64'(bus_ready), 64'd0);

        // second reset clears sticky bits
        access(1'b1, 10'h1C, 32'hF, 1'b0, "R5 set locks");
        access(1'b1, 10'h20, 32'hFFFF_FFFF, 1'b0, "R7 set wp1");
        do_reset();
        check_all("R1 R5 R7 after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule